// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Terminal Outputs

This block is a presettable binary counter, four bits wide by default, with no direction bit. Instead it has two strobe inputs. A rising edge on the up strobe adds one to the count, and a rising edge on the down strobe subtracts one. Each strobe is brought into the system clock domain through a short flip-flop chain. A small per-strobe tracker then turns the synchronised level into a one-cycle rise indication. The tracker has two states: `TRK_HIGH` (last sample high) and `TRK_LOW` (last sample low). It moves from `TRK_HIGH` to `TRK_LOW` on a low sample. It moves from `TRK_LOW` back to `TRK_HIGH` on a high sample, and this second transition is the rise that gets counted.

Every system clock cycle, the count register picks one of five operations: `OP_CLEAR`, `OP_LOAD`, `OP_INC`, `OP_DEC` or `OP_HOLD`. A high master clear beats everything else. A low load input comes next and copies the data input into the count. After that, a single accepted strobe rise counts. The two active-low terminal outputs follow the synchronised strobe levels.

- The up terminal goes low while the count is at its maximum and the up strobe is low.
- The down terminal goes low while the count is zero and the down strobe is low.

Each terminal output therefore copies the low phase of its strobe. Wiring the terminals of one instance to the strobes of the next gives a wider ripple-cascaded counter.

Top module: `udc_counter`

## Requirements
- R1: A rising edge on `up_stb` while `dn_stb` stays high increments `q` by one. The new value appears on the third rising system clock edge after the strobe change.
- R2: A rising edge on `dn_stb` while `up_stb` stays high decrements `q` by one, with the same latency as R1.
- R3: While `clr` is high, `q` is forced to zero on each clock edge. This holds whatever the values of `load_n`, `din` and both strobes.
- R4: While `load_n` is low and `clr` is low, `q` takes `din` on each clock edge, and strobe edges have no effect on `q`.
- R5: `tcu_n` is low exactly when `q` is all ones and the synchronised `up_stb` is low. It returns high when the up strobe goes high again.
- R6: `tcd_n` is low exactly when `q` is zero and the synchronised `dn_stb` is low.
- R7: If a strobe is low during a clear or load and stays low afterwards, its next rising edge is counted.
- R8: When two instances are chained, each stage's `tcu_n` drives the next stage's `up_stb` and each `tcd_n` drives the next `dn_stb`. The pair then counts as a single binary counter of twice the width, in both directions.
- R9: Counting wraps in binary: from all ones up to zero, and from zero down to all ones.
- R10: If rising edges on both strobes are accepted in the same system cycle, `q` is unchanged.
- R11: A rising edge on one strobe while the other strobe is low leaves `q` unchanged.
- R12: After `rst_n` is released, `q` is zero and both terminal outputs are high while both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset for the synchronisers, trackers and count |
| clr | input | 1 | Active-high master clear, highest priority |
| load_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Parallel load data |
| up_stb | input | 1 | Count-up strobe, acts on its rising edge |
| dn_stb | input | 1 | Count-down strobe, acts on its rising edge |
| q | output | WIDTH | Current count |
| tcu_n | output | 1 | Up terminal, low at all ones while the up strobe is low |
| tcd_n | output | 1 | Down terminal, low at zero while the down strobe is low |

## Verification
The bench builds the default configuration, `WIDTH` = 4 and `SYNC_STAGES` = 2, and chains two copies through their terminal outputs. This forms an 8-bit counter with only 256 states. Sweeps of 300 strobe pulses upward and then 300 downward therefore pass through every count value and both wrap points. Every carry and borrow between the stages is checked against an arithmetic model, along with the terminal level in every pulse. Because the counter is this small, the priority, load, simultaneous-edge and low-strobe corner cases can each be set up directly from a few chosen preload values.

// File: rtl/udc_pkg.sv
package udc_pkg;

    typedef enum logic {
        TRK_HIGH = 1'b0,
        TRK_LOW  = 1'b1
    } trk_state_t;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } cnt_op_t;

endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/udc_strobe_trk.sv
module udc_strobe_trk
    import udc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    trk_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TRK_HIGH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TRK_HIGH: if (!lvl) state_nx = TRK_LOW;
            TRK_LOW:  if (lvl)  state_nx = TRK_HIGH;
            default:            state_nx = TRK_HIGH;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        unique case (state)
            TRK_HIGH: rise = 1'b0;
            TRK_LOW:  rise = lvl;
            default:  rise = 1'b0;
        endcase
    end

    assert_rise_after_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (state == TRK_LOW));
endmodule

// File: rtl/udc_core.sv
module udc_core
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             up_rise,
    input  logic             dn_rise,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic [WIDTH-1:0] cnt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    cnt_op_t op;

    always_comb begin
        if (clr)                                op = OP_CLEAR;
        else if (!load_n)                       op = OP_LOAD;
        else if (up_rise && !dn_rise && dn_lvl) op = OP_INC;
        else if (dn_rise && !up_rise && up_lvl) op = OP_DEC;
        else                                    op = OP_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: cnt <= '0;
                OP_LOAD:  cnt <= din;
                OP_INC:   cnt <= cnt + ONE;
                OP_DEC:   cnt <= cnt - ONE;
                default:  cnt <= cnt;
            endcase
        end
    end

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    assert_load_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (cnt == $past(din)));
    assert_both_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && up_rise && dn_rise) |=> $stable(cnt));
    assert_other_low_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && up_rise && !dn_lvl && !dn_rise) |=> $stable(cnt));
    assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && up_rise && dn_lvl && !dn_rise) |=> (cnt == $past(cnt) + ONE));
endmodule

// File: rtl/udc_counter.sv
module udc_counter
    import udc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             up_stb,
    input  logic             dn_stb,
    output logic [WIDTH-1:0] q,
    output logic             tcu_n,
    output logic             tcd_n
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic up_lvl, dn_lvl, up_rise, dn_rise;

    udc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_up (
        .clk(clk), .rst_n(rst_n), .d(up_stb), .q(up_lvl));
    udc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dn (
        .clk(clk), .rst_n(rst_n), .d(dn_stb), .q(dn_lvl));

    udc_strobe_trk u_trk_up (.clk(clk), .rst_n(rst_n), .lvl(up_lvl), .rise(up_rise));
    udc_strobe_trk u_trk_dn (.clk(clk), .rst_n(rst_n), .lvl(dn_lvl), .rise(dn_rise));

    udc_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
        .up_rise(up_rise), .dn_rise(dn_rise), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
        .cnt(q));

    always_comb begin
        tcu_n = !((q == CNT_MAX) && !up_lvl);
        tcd_n = !((q == '0) && !dn_lvl);
    end

    assert_tcu_at_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tcu_n |-> (q == CNT_MAX));
    assert_tcd_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tcd_n |-> (q == '0));
    assert_wrap_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tcu_n && !clr && load_n && !dn_rise && dn_lvl) |=> (q == CNT_MAX || q == '0));
endmodule

// File: tb/sim_udc_counter.sv
module sim_udc_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] din_lo = 4'd0;
    logic [3:0] din_hi = 4'd0;
    logic       up = 1'b1;
    logic       dn = 1'b1;
    logic [3:0] q0, q1;
    logic       tcu0, tcd0, tcu1, tcd1;

    int vectors = 0;
    int errors  = 0;
    int model   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    udc_counter #(.WIDTH(4), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din_lo),
        .up_stb(up), .dn_stb(dn), .q(q0), .tcu_n(tcu0), .tcd_n(tcd0));

    udc_counter #(.WIDTH(4), .SYNC_STAGES(2)) u1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din_hi),
        .up_stb(tcu0), .dn_stb(tcd0), .q(q1), .tcu_n(tcu1), .tcd_n(tcd1));

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic pulse_up();
        up = 1'b0;
        wait_n(10);
        check("R5 tcu low phase", int'(tcu0), (model % 16 == 15) ? 0 : 1);
        up = 1'b1;
        wait_n(10);
        model = (model + 1) % 256;
        check("R1 R8 R9 up count", int'({q1, q0}), model);
        check("R5 tcu released", int'(tcu0), 1);
    endtask

    task automatic pulse_dn();
        dn = 1'b0;
        wait_n(10);
        check("R6 tcd low phase", int'(tcd0), (model % 16 == 0) ? 0 : 1);
        dn = 1'b1;
        wait_n(10);
        model = (model + 255) % 256;
        check("R2 R8 R9 down count", int'({q1, q0}), model);
        check("R6 tcd released", int'(tcd0), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);
        check("R12 reset count", int'({q1, q0}), 0);
        check("R12 reset tcu", int'(tcu0), 1);
        check("R12 reset tcd", int'(tcd0), 1);

        for (int i = 0; i < 300; i++) pulse_up();
        for (int i = 0; i < 300; i++) pulse_dn();

        // R4: load holds against strobe edges
        din_lo = 4'hA; din_hi = 4'h3;
        load_n = 1'b0;
        wait_n(2);
        up = 1'b0; wait_n(8); up = 1'b1; wait_n(8);
        check("R4 load during strobe", int'(q0), 10);
        load_n = 1'b1;
        wait_n(4);
        check("R4 load value", int'({q1, q0}), 16'h3A);

        // R3: clear overrides load and strobes
        clr = 1'b0; load_n = 1'b0; clr = 1'b1;
        up = 1'b0; wait_n(8); up = 1'b1; wait_n(8);
        check("R3 clear over load", int'({q1, q0}), 0);
        load_n = 1'b1; clr = 1'b0;
        wait_n(4);
        check("R3 clear persists", int'({q1, q0}), 0);

        // R7: strobe low across a clear, next rise counts
        up = 1'b0;
        wait_n(6);
        clr = 1'b1; wait_n(3); clr = 1'b0;
        wait_n(6);
        up = 1'b1;
        wait_n(10);
        check("R7 count after clear", int'(q0), 1);

        // R10: both strobes rise in the same cycle
        din_lo = 4'd5; din_hi = 4'd0;
        load_n = 1'b0; wait_n(2); load_n = 1'b1;
        wait_n(2);
        up = 1'b0; dn = 1'b0;
        wait_n(8);
        up = 1'b1; dn = 1'b1;
        wait_n(10);
        check("R10 both edges hold", int'(q0), 5);

        // R11: up edge while down strobe is low
        dn = 1'b0;
        wait_n(6);
        up = 1'b0; wait_n(8); up = 1'b1; wait_n(10);
        check("R11 up ignored", int'(q0), 5);
        dn = 1'b1;
        wait_n(10);
        check("R2 down after hold", int'(q0), 4);

        finish_run();
    end
endmodule